// File: doc/BRIEF.md
# Platform System Control Register Block

This block holds the byte-wide control and status ports that a platform exposes on its I/O port bus. A host drives an address, write data and a write strobe to change state, or an address and a read strobe to fetch a byte. The block keeps a small set of state bits and drives them onto its outputs. These are a hard-reset request to the CPU, a drive activity lamp, a 4-bit system control value and a bit that selects the I/O map mode. Two further ports do not store anything. A write to either one only produces a single-cycle lock-toggle pulse, which the nonvolatile memory beside the block consumes.

Several kinds of port share one decoder. Identity and feature ports return fixed constants. Control ports store only a masked part of each write. Strobe ports act on a write and are never read back. The reset port combines a write-side reset request with a read-side report of the endian mode, which comes in on an input pin. Every port address is a parameter. Any address that the decoder does not match reads as all ones. A write to such an address changes nothing.

Top module: `sysctl_regs`

## Requirements
- R1: A write to the reset port sets `cpu_hreset` to bit 0 of the write data from the cycle after the write. A 1 asserts the request and a 0 releases it.
- R2: A read of the reset port returns `endian_big` in bit 1 and zero in every other bit.
- R3: The identity ports read as fixed bytes: CPU configuration 0xEF, base feature 0xAD, base status 0xE0 and extended feature 0x39. Writes to these ports change no output and no read value.
- R4: A write to the control port stores bits 3:0 of the data on `ctrl_val`. A read of that port returns the stored value with bits 7:4 zero.
- R5: A write to the map-type port stores bit 0 of the data on `map_noncontig`, where 0 means contiguous and 1 means non-contiguous. A read returns the stored bit in bit 0 with the other bits zero.
- R6: A read of the cache status port always returns 0x03.
- R7: A write to lock port 1 drives `lock1_pulse` high for exactly the cycle after the write, and `lock2_pulse` stays low. Lock port 2 behaves the same way on `lock2_pulse`.
- R8: A read of an undecoded address returns 0xFF. The write-only ports (lamp, lock 1, lock 2) also read 0xFF. A write to an undecoded address changes no output.
- R9: A write to the lamp port sets `lamp_on` to bit 0 of the write data from the cycle after the write.
- R10: While `rst_n` is low, `cpu_hreset`, `lamp_on`, `ctrl_val`, `map_noncontig` and both lock pulses are 0, and `rdata` is 0xFF.
- R11: With the default registered read path, `rdata` shows the selected byte from the cycle after `rd_en` is high. It holds that byte until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (16) | Port address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| endian_big | input | 1 | Current endian mode, reported by the reset port |
| rdata | output | 8 | Read data |
| cpu_hreset | output | 1 | CPU hard-reset request |
| lamp_on | output | 1 | Drive activity lamp |
| lock1_pulse | output | 1 | Lock-toggle pulse for lock 1 |
| lock2_pulse | output | 1 | Lock-toggle pulse for lock 2 |
| ctrl_val | output | 4 | Stored system control value |
| map_noncontig | output | 1 | I/O map mode, 1 for non-contiguous |

## Verification
Every result arrives one clock edge after its strobe. Stored outputs and lock pulses follow the write edge, and `rdata` follows the read edge. The bench raises a strobe on a falling edge, drops it on the next falling edge, and compares the outputs at that point. Each lock pulse is checked again one falling edge later, when it must already be low. Read data is also checked on an idle cycle after a read to show that it holds.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   // Index of each decoded port within the address table
   typedef enum int {
      PI_RST    = 0,
      PI_CPUCFG = 1,
      PI_FEAT   = 2,
      PI_STAT   = 3,
      PI_EXTF   = 4,
      PI_L2     = 5,
      PI_LAMP   = 6,
      PI_LOCK1  = 7,
      PI_LOCK2  = 8,
      PI_SYSCTL = 9,
      PI_MAP    = 10
   } port_idx_e;

   localparam int NPORT = 11;

   localparam logic [7:0] ID_CPUCFG = 8'hEF;
   localparam logic [7:0] ID_FEAT   = 8'hAD;
   localparam logic [7:0] ID_STAT   = 8'hE0;
   localparam logic [7:0] ID_EXTF   = 8'h39;
   localparam logic [7:0] L2_NONE   = 8'h03;
   localparam logic [7:0] RD_MISS   = 8'hFF;

   typedef struct packed {
      logic       hreset;
      logic       lamp;
      logic       lock1;
      logic       lock2;
      logic [3:0] ctrl;
      logic       map;
   } sysctl_state_t;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int                    AW    = 16,
   parameter logic [NPORT*AW-1:0]   TABLE = '0
) (
   input  logic [AW-1:0]    addr,
   output logic [NPORT-1:0] hit
);

   for (genvar i = 0; i < NPORT; i++) begin : g_cmp
      assign hit[i] = (addr == TABLE[i*AW +: AW]);
      for (genvar j = i + 1; j < NPORT; j++) begin : g_uniq
         initial assert (TABLE[i*AW +: AW] != TABLE[j*AW +: AW])
            else $error("sysctl_decode: port %0d and %0d share an address", i, j);
      end
   end

endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
   import sysctl_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wdata,
   input  logic          hit_rst,
   input  logic          hit_lamp,
   input  logic          hit_lock1,
   input  logic          hit_lock2,
   input  logic          hit_ctrl,
   input  logic          hit_map,
   output sysctl_state_t st
);

   logic unused_hi;
   assign unused_hi = ^wdata[7:4];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         st.lock1 <= wr_en & hit_lock1;
         st.lock2 <= wr_en & hit_lock2;
         if (wr_en) begin
            if (hit_rst)  st.hreset <= wdata[0];
            if (hit_lamp) st.lamp   <= wdata[0];
            if (hit_ctrl) st.ctrl   <= wdata[3:0];
            if (hit_map)  st.map    <= wdata[0];
         end
      end
   end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter bit RDATA_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [NPORT-1:0] hit,
   input  logic             endian_big,
   input  sysctl_state_t    st,
   output logic [7:0]       rdata
);

   logic [7:0] sel;
   logic       unused_in;
   assign unused_in = ^{hit[PI_LAMP], hit[PI_LOCK1], hit[PI_LOCK2],
                        st.hreset, st.lamp, st.lock1, st.lock2};

   always_comb begin
      sel = RD_MISS;
      if (hit[PI_RST])    sel = {6'b0, endian_big, 1'b0};
      if (hit[PI_CPUCFG]) sel = ID_CPUCFG;
      if (hit[PI_FEAT])   sel = ID_FEAT;
      if (hit[PI_STAT])   sel = ID_STAT;
      if (hit[PI_EXTF])   sel = ID_EXTF;
      if (hit[PI_L2])     sel = L2_NONE;
      if (hit[PI_SYSCTL]) sel = {4'b0, st.ctrl};
      if (hit[PI_MAP])    sel = {7'b0, st.map};
   end

   if (RDATA_REG) begin : g_reg
      logic [7:0] rq;
      always_ff @(posedge clk) begin
         if (!rst_n)     rq <= RD_MISS;
         else if (rd_en) rq <= sel;
      end
      assign rdata = rq;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata = rd_en ? sel : RD_MISS;
   end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int          AW        = 16,
   parameter bit          RDATA_REG = 1'b1,
   parameter logic [AW-1:0] A_RST    = 16'h0092,
   parameter logic [AW-1:0] A_CPUCFG = 16'h0800,
   parameter logic [AW-1:0] A_FEAT   = 16'h0801,
   parameter logic [AW-1:0] A_STAT   = 16'h0802,
   parameter logic [AW-1:0] A_EXTF   = 16'h0803,
   parameter logic [AW-1:0] A_L2     = 16'h0804,
   parameter logic [AW-1:0] A_LAMP   = 16'h0808,
   parameter logic [AW-1:0] A_LOCK1  = 16'h0809,
   parameter logic [AW-1:0] A_LOCK2  = 16'h080A,
   parameter logic [AW-1:0] A_SYSCTL = 16'h080C,
   parameter logic [AW-1:0] A_MAP    = 16'h080F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic          endian_big,
   output logic [7:0]    rdata,
   output logic          cpu_hreset,
   output logic          lamp_on,
   output logic          lock1_pulse,
   output logic          lock2_pulse,
   output logic [3:0]    ctrl_val,
   output logic          map_noncontig
);

   // Table ordered by port_idx_e, highest index in the top slice
   localparam logic [NPORT*AW-1:0] TABLE = {A_MAP, A_SYSCTL, A_LOCK2, A_LOCK1, A_LAMP,
                                            A_L2, A_EXTF, A_STAT, A_FEAT, A_CPUCFG, A_RST};

   initial assert (AW >= 8 && AW <= 32) else $error("sysctl_regs: AW out of range");

   logic [NPORT-1:0] hit;
   sysctl_state_t    st;

   sysctl_decode #(.AW(AW), .TABLE(TABLE)) u_dec (
      .addr (addr),
      .hit  (hit)
   );

   sysctl_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wdata     (wdata),
      .hit_rst   (hit[PI_RST]),
      .hit_lamp  (hit[PI_LAMP]),
      .hit_lock1 (hit[PI_LOCK1]),
      .hit_lock2 (hit[PI_LOCK2]),
      .hit_ctrl  (hit[PI_SYSCTL]),
      .hit_map   (hit[PI_MAP]),
      .st        (st)
   );

   sysctl_rdmux #(.RDATA_REG(RDATA_REG)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .hit        (hit),
      .endian_big (endian_big),
      .st         (st),
      .rdata      (rdata)
   );

   assign cpu_hreset    = st.hreset;
   assign lamp_on       = st.lamp;
   assign lock1_pulse   = st.lock1;
   assign lock2_pulse   = st.lock2;
   assign ctrl_val      = st.ctrl;
   assign map_noncontig = st.map;

endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
   parameter int          AW       = 16,
   parameter logic [AW-1:0] A_RST    = 16'h0092,
   parameter logic [AW-1:0] A_CPUCFG = 16'h0800,
   parameter logic [AW-1:0] A_L2     = 16'h0804,
   parameter logic [AW-1:0] A_LAMP   = 16'h0808,
   parameter logic [AW-1:0] A_LOCK1  = 16'h0809,
   parameter logic [AW-1:0] A_LOCK2  = 16'h080A,
   parameter logic [AW-1:0] A_SYSCTL = 16'h080C,
   parameter logic [AW-1:0] A_MAP    = 16'h080F,
   parameter bit          RDATA_REG = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] addr,
   input logic [7:0]    wdata,
   input logic          wr_en,
   input logic          rd_en,
   input logic [7:0]    rdata,
   input logic          cpu_hreset,
   input logic          lamp_on,
   input logic          lock1_pulse,
   input logic          lock2_pulse,
   input logic [3:0]    ctrl_val,
   input logic          map_noncontig
);

   AST_RST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_RST) |=> (cpu_hreset == $past(wdata[0])));  // R1

   AST_LAMP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_LAMP) |=> (lamp_on == $past(wdata[0])));  // R9

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_SYSCTL) |=> $stable(ctrl_val));  // R4

   AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_MAP) |=> $stable(map_noncontig));  // R5

   AST_LOCK1_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock1_pulse) |-> $past(wr_en && addr == A_LOCK1));  // R7

   AST_LOCK2_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_LOCK2) ##1 !(wr_en && addr == A_LOCK2) |=> !lock2_pulse);  // R7

   AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lock1_pulse, lock2_pulse}));  // R7

   if (RDATA_REG) begin : g_rd
      AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr == A_CPUCFG) |=> (rdata == 8'hEF));  // R3

      AST_L2_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_en && addr == A_L2) |=> (rdata == 8'h03));  // R6

      AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> $stable(rdata));  // R11
   end

endmodule

bind sysctl_regs sysctl_regs_chk #(
   .AW(AW), .A_RST(A_RST), .A_CPUCFG(A_CPUCFG), .A_L2(A_L2), .A_LAMP(A_LAMP),
   .A_LOCK1(A_LOCK1), .A_LOCK2(A_LOCK2), .A_SYSCTL(A_SYSCTL), .A_MAP(A_MAP),
   .RDATA_REG(RDATA_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
   .rd_en(rd_en), .rdata(rdata), .cpu_hreset(cpu_hreset), .lamp_on(lamp_on),
   .lock1_pulse(lock1_pulse), .lock2_pulse(lock2_pulse), .ctrl_val(ctrl_val),
   .map_noncontig(map_noncontig)
);

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;

   localparam logic [15:0] A_RST = 16'h0092, A_CPUCFG = 16'h0800, A_FEAT = 16'h0801,
                           A_STAT = 16'h0802, A_EXTF = 16'h0803, A_L2 = 16'h0804,
                           A_LAMP = 16'h0808, A_LOCK1 = 16'h0809, A_LOCK2 = 16'h080A,
                           A_SYSCTL = 16'h080C, A_MAP = 16'h080F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr_en = 1'b0, rd_en = 1'b0, endian_big = 1'b0;
   logic [7:0]  rdata;
   logic        cpu_hreset, lamp_on, lock1_pulse, lock2_pulse, map_noncontig;
   logic [3:0]  ctrl_val;

   int nvec = 0, nerr = 0;

   // bench model of stored state
   logic       m_hreset = 0, m_lamp = 0, m_map = 0;
   logic [3:0] m_ctrl = 0;

   always #5 clk = ~clk;

   sysctl_regs i_sysctl_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .endian_big(endian_big), .rdata(rdata),
      .cpu_hreset(cpu_hreset), .lamp_on(lamp_on), .lock1_pulse(lock1_pulse),
      .lock2_pulse(lock2_pulse), .ctrl_val(ctrl_val), .map_noncontig(map_noncontig)
   );

   function automatic logic [7:0] exp_read(input logic [15:0] a, input logic e);
      case (a)
         A_RST:    return {6'b0, e, 1'b0};      // R2
         A_CPUCFG: return 8'hEF;                // R3
         A_FEAT:   return 8'hAD;
         A_STAT:   return 8'hE0;
         A_EXTF:   return 8'h39;
         A_L2:     return 8'h03;                // R6
         A_SYSCTL: return {4'b0, m_ctrl};       // R4
         A_MAP:    return {7'b0, m_map};        // R5
         default:  return 8'hFF;                // R8
      endcase
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req);
      chk({req, " hreset R1"}, {7'b0, cpu_hreset}, {7'b0, m_hreset});
      chk({req, " lamp R9"},   {7'b0, lamp_on},    {7'b0, m_lamp});
      chk({req, " ctrl R4"},   {4'b0, ctrl_val},   {4'b0, m_ctrl});
      chk({req, " map R5"},    {7'b0, map_noncontig}, {7'b0, m_map});
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         A_RST:    m_hreset = d[0];
         A_LAMP:   m_lamp   = d[0];
         A_SYSCTL: m_ctrl   = d[3:0];
         A_MAP:    m_map    = d[0];
         default: ;
      endcase
      chk_state(req);
      chk({req, " lock1 R7"}, {7'b0, lock1_pulse}, {7'b0, (a == A_LOCK1)});
      chk({req, " lock2 R7"}, {7'b0, lock2_pulse}, {7'b0, (a == A_LOCK2)});
      @(negedge clk);
      chk({req, " lock1 low R7"}, {7'b0, lock1_pulse}, 8'h00);
      chk({req, " lock2 low R7"}, {7'b0, lock2_pulse}, 8'h00);
   endtask

   task automatic do_read(input logic [15:0] a, input logic e, input bit hold, input string req);
      logic [7:0] x;
      @(negedge clk);
      addr = a; endian_big = e; rd_en = 1'b1;
      x = exp_read(a, e);
      @(negedge clk);
      rd_en = 1'b0;
      chk(req, rdata, x);
      if (hold) begin
         addr = 16'h0123; endian_big = ~e;
         @(negedge clk);
         chk({req, " hold R11"}, rdata, x);
      end
   endtask

   initial begin
      #2000000;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      logic [15:0] pool [12];
      pool = '{A_RST, A_CPUCFG, A_FEAT, A_STAT, A_EXTF, A_L2, A_LAMP,
               A_LOCK1, A_LOCK2, A_SYSCTL, A_MAP, 16'h0000};
      void'($urandom(32'd1234));

      repeat (3) @(negedge clk);
      // R10 reset state
      chk_state("R10 reset");
      chk("R10 lock1", {7'b0, lock1_pulse}, 8'h00);
      chk("R10 lock2", {7'b0, lock2_pulse}, 8'h00);
      chk("R10 rdata", rdata, 8'hFF);
      rst_n = 1'b1;

      // directed corner cases
      do_read(A_CPUCFG, 1'b0, 1'b1, "R3 cpucfg");
      do_read(A_FEAT,   1'b0, 1'b0, "R3 feat");
      do_read(A_STAT,   1'b0, 1'b0, "R3 stat");
      do_read(A_EXTF,   1'b0, 1'b0, "R3 extf");
      do_write(A_CPUCFG, 8'h00, "R3 write ignored");
      do_read(A_CPUCFG, 1'b0, 1'b0, "R3 cpucfg after write");
      do_read(A_L2, 1'b0, 1'b0, "R6 l2");
      do_read(A_RST, 1'b1, 1'b0, "R2 endian 1");
      do_read(A_RST, 1'b0, 1'b0, "R2 endian 0");
      do_write(A_RST, 8'hFF, "R1 assert");
      do_write(A_RST, 8'hFE, "R1 release");
      do_write(A_SYSCTL, 8'hA7, "R4 mask");
      do_read(A_SYSCTL, 1'b0, 1'b1, "R4 readback");
      do_write(A_MAP, 8'hFF, "R5 set");
      do_read(A_MAP, 1'b0, 1'b0, "R5 readback");
      do_write(A_MAP, 8'hFE, "R5 clear");
      do_write(A_LAMP, 8'h01, "R9 on");
      do_write(A_LAMP, 8'h00, "R9 off");
      do_write(A_LOCK1, 8'h55, "R7 lock1");
      do_write(A_LOCK2, 8'hAA, "R7 lock2");
      do_read(A_LAMP, 1'b0, 1'b0, "R8 lamp write-only");
      do_read(A_LOCK1, 1'b0, 1'b0, "R8 lock write-only");
      do_read(16'h1234, 1'b0, 1'b1, "R8 undecoded read");
      do_write(16'hBEEF, 8'hFF, "R8 undecoded write");

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         logic [7:0]  d;
         a = pool[$urandom_range(11)];
         if (a == 16'h0000) a = 16'($urandom_range(16'hFFFF));
         d = 8'($urandom);
         if ($urandom_range(1)) do_write(a, d, "rand write");
         else do_read(a, 1'($urandom), 1'($urandom), "rand read R11");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule